// File: doc/BRIEF.md
# Resource Description Byte Reader

This block lets a host walk a card's resource description one byte at a time. The description sits in a small internal ROM. The host reaches the block through two register indices. A status index reports in bit 0 whether the next byte can be fetched. A data index returns that byte and moves an internal pointer forward by one.

After each accepted byte the ready flag drops for a fixed number of cycles. This models the time the card takes to fetch the following byte, so the host must poll the status index before every data read.

The block decodes the item headers as the bytes stream past, so it knows where the stream ends. A header with bit 7 clear is a small item: bits 6:3 hold its name and bits 2:0 hold its payload length. A header with bit 7 set is a large item: a 16-bit length follows it, low byte first, and then the payload. A small item named 0xF closes the stream. Once that item's payload has been read (normally one checksum byte), the pointer freezes. A wake pulse rewinds the pointer to the first byte and clears the end state.

Top module: `resdata_reader`

## Requirements
- R1: While reset is held, rd_data is 0x00. In each of the first FETCH_CYCLES cycles after reset is released, a status read returns 0x00. In the following cycle it returns 0x01.
- R2: A data read (index IDX_DATA, default 0x04) issued while ready returns the ROM byte at the pointer on rd_data in the next cycle, and advances the pointer by one.
- R3: A status read (index IDX_STATUS, default 0x05) returns the ready flag in bit 0 with bits 7:1 zero, on rd_data in the next cycle.
- R4: Consider a status read strobed j cycles after an accepted data read, with j at least 1. It returns 1 only when j exceeds FETCH_CYCLES.
- R5: A data read issued while not ready returns 0x00 and leaves the pointer where it was.
- R6: Item headers are decoded as follows:
  - Small item: bit 7 = 0, name in bits 6:3, count in bits 2:0.
  - Large item: bit 7 = 1, followed by a 16-bit length, low byte first.
  - Payload bytes are never taken as headers, even when a payload byte looks like the end header.
- R7: After the payload of a small item named 0xF has been read, every further data read returns 0x00, the pointer holds, and status keeps reading 0x01.
- R8: A wake pulse has these effects:
  - The pointer returns to byte 0 and the end state clears.
  - Ready stays low for FETCH_CYCLES cycles afterwards.
  - A data read strobed in the same cycle as the wake returns 0x00.
- R9: A read of any index other than the data and status indices returns 0x00 and does not move the pointer.
- R10: If no end item occurs, the pointer stops after the last ROM entry (ROM_DEPTH-1) has been read, and later data reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | One-cycle pulse: rewind pointer to byte 0 |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_idx | input | 8 | Register index of the read |
| rd_data | output | 8 | Registered read result, valid the cycle after the strobe |

## Verification
A pointer that slips or moves twice shows up on the very next accepted data read as a byte out of sequence. A parser that loses its place inside a payload shows up as an early run of 0x00 bytes, or as a stream that runs past the checksum. The ROM image therefore places end-header lookalikes inside both small and large payloads. A ready counter with the wrong reload value is visible within FETCH_CYCLES+1 status reads of any data read or wake, because the exact cycle in which bit 0 rises is checked.

// File: rtl/resdata_pkg.sv
package resdata_pkg;

  typedef enum logic [2:0] {
    PS_HEAD,
    PS_LEN_LO,
    PS_LEN_HI,
    PS_BODY,
    PS_END
  } parse_state_t;

  localparam logic [3:0] END_ITEM_NAME = 4'hF;
  localparam int         LEN_W         = 16;

  // Image 0: terminated description with end-header lookalikes in payloads.
  // Image 1: a single endless large item (no end tag).
  function automatic logic [7:0] image_byte(input int sel, input int idx);
    logic [7:0] b;
    if (sel == 1) begin
      if (idx == 0)                  b = 8'h84;
      else if (idx == 1 || idx == 2) b = 8'hFF;
      else                           b = 8'(idx * 3 + 1);
    end else begin
      case (idx)
        0:  b = 8'h0A;
        1:  b = 8'h10;
        2:  b = 8'h00;
        3:  b = 8'h15;
        4:  b = 8'h41;
        5:  b = 8'h78;
        6:  b = 8'h79;
        7:  b = 8'h44;
        8:  b = 8'h45;
        9:  b = 8'h82;
        10: b = 8'h03;
        11: b = 8'h00;
        12: b = 8'h79;
        13: b = 8'h78;
        14: b = 8'h00;
        15: b = 8'h22;
        16: b = 8'h20;
        17: b = 8'h00;
        18: b = 8'h79;
        19: b = 8'h5A;
        default: b = 8'hEE;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/resdata_rom.sv
module resdata_rom #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int IMAGE = 0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = resdata_pkg::image_byte(IMAGE, i);
  end

  // synchronous read port, block-RAM friendly
  always_ff @(posedge clk) begin
    q <= mem[addr];
  end
endmodule

// File: rtl/resdata_parser.sv
module resdata_parser
  import resdata_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       consume,
  input  logic [7:0] byte_in,
  output logic       done
);
  parse_state_t     state_q;
  logic [LEN_W-1:0] remain_q;
  logic [7:0]       len_lo_q;
  logic             is_end_q;

  logic             small_is_end;
  logic [LEN_W-1:0] large_len;

  assign small_is_end = (byte_in[6:3] == END_ITEM_NAME);
  assign large_len    = {byte_in, len_lo_q};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q  <= PS_HEAD;
      remain_q <= '0;
      len_lo_q <= '0;
      is_end_q <= 1'b0;
    end else if (consume) begin
      case (state_q)
        PS_HEAD: begin
          if (!byte_in[7]) begin
            is_end_q <= small_is_end;
            remain_q <= LEN_W'(byte_in[2:0]);
            if (byte_in[2:0] == 3'd0) state_q <= small_is_end ? PS_END : PS_HEAD;
            else                      state_q <= PS_BODY;
          end else begin
            is_end_q <= 1'b0;
            state_q  <= PS_LEN_LO;
          end
        end
        PS_LEN_LO: begin
          len_lo_q <= byte_in;
          state_q  <= PS_LEN_HI;
        end
        PS_LEN_HI: begin
          remain_q <= large_len;
          state_q  <= (large_len == '0) ? PS_HEAD : PS_BODY;
        end
        PS_BODY: begin
          remain_q <= remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) state_q <= is_end_q ? PS_END : PS_HEAD;
        end
        PS_END:  state_q <= PS_END;
        default: state_q <= PS_HEAD;
      endcase
    end
  end

  assign done = (state_q == PS_END);
endmodule

// File: rtl/resdata_pacer.sv
module resdata_pacer #(
  parameter int FETCH_CYCLES = 2,
  parameter int CW           = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic ready
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)       cnt_q <= CW'(FETCH_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/resdata_reader.sv
module resdata_reader #(
  parameter int         ROM_DEPTH    = 64,
  parameter int         FETCH_CYCLES = 2,
  parameter int         IMAGE_SEL    = 0,
  parameter logic [7:0] IDX_DATA     = 8'h04,
  parameter logic [7:0] IDX_STATUS   = 8'h05
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake,
  input  logic       reg_rd,
  input  logic [7:0] reg_idx,
  output logic [7:0] rd_data
);
  localparam int               PTR_W    = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
  localparam int               CNT_W    = $clog2(FETCH_CYCLES + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(ROM_DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       rom_q;
  logic             ready;
  logic             parse_done;
  logic             exhausted_q;
  logic             at_end;
  logic             data_hit;
  logic             stat_hit;
  logic             take;

  assign data_hit = reg_rd && (reg_idx == IDX_DATA);
  assign stat_hit = reg_rd && (reg_idx == IDX_STATUS);
  assign at_end   = parse_done || exhausted_q;
  assign take     = data_hit && ready && !at_end && !wake;

  resdata_rom #(.DEPTH(ROM_DEPTH), .AW(PTR_W), .IMAGE(IMAGE_SEL)) u_rom (
    .clk  (clk),
    .addr (ptr_q),
    .q    (rom_q)
  );

  resdata_parser u_parser (
    .clk     (clk),
    .rst     (rst),
    .clear   (wake),
    .consume (take),
    .byte_in (rom_q),
    .done    (parse_done)
  );

  resdata_pacer #(.FETCH_CYCLES(FETCH_CYCLES), .CW(CNT_W)) u_pacer (
    .clk     (clk),
    .rst     (rst),
    .restart (take || wake),
    .ready   (ready)
  );

  always_ff @(posedge clk) begin
    if (rst || wake) begin
      ptr_q       <= '0;
      exhausted_q <= 1'b0;
    end else if (take) begin
      if (ptr_q == LAST_PTR) exhausted_q <= 1'b1;
      else                   ptr_q       <= ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else if (reg_rd) begin
      if (take)          rd_data <= rom_q;
      else if (stat_hit) rd_data <= {7'b0, ready};
      else               rd_data <= 8'h00;
    end
  end
endmodule

// File: rtl/resdata_reader_chk.sv
module resdata_reader_chk #(
  parameter int         PTR_W      = 6,
  parameter int         ROM_DEPTH  = 64,
  parameter logic [7:0] IDX_DATA   = 8'h04,
  parameter logic [7:0] IDX_STATUS = 8'h05
) (
  input logic             clk,
  input logic             rst,
  input logic             wake,
  input logic             reg_rd,
  input logic [7:0]       reg_idx,
  input logic [7:0]       rd_data,
  input logic             take,
  input logic             ready,
  input logic [PTR_W-1:0] ptr,
  input logic             at_end
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ROM_DEPTH - 1);

  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    take && ptr != LAST |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));

  p_status_bits_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_idx == IDX_STATUS |=> rd_data == {7'b0, $past(ready)});

  p_busy_after_take_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> !ready);

  p_refused_zero_r5: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_idx == IDX_DATA && !ready |=> rd_data == 8'h00);

  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !take && !wake |=> $stable(ptr));

  p_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    at_end && !wake |=> at_end && $stable(ptr));

  p_end_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_idx == IDX_DATA && at_end |=> rd_data == 8'h00);

  p_wake_rewind_r8: assert property (@(posedge clk) disable iff (rst)
    wake |=> ptr == '0 && !ready && !at_end);

  p_other_idx_r9: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_idx != IDX_DATA && reg_idx != IDX_STATUS |=> rd_data == 8'h00);
endmodule

bind resdata_reader resdata_reader_chk #(
  .PTR_W(PTR_W), .ROM_DEPTH(ROM_DEPTH), .IDX_DATA(IDX_DATA), .IDX_STATUS(IDX_STATUS)
) u_chk (
  .clk(clk), .rst(rst), .wake(wake), .reg_rd(reg_rd), .reg_idx(reg_idx),
  .rd_data(rd_data), .take(take), .ready(ready), .ptr(ptr_q), .at_end(at_end)
);

// File: tb/resdata_reader_bench.sv
module resdata_reader_bench;
  localparam int         FETCH = 3;
  localparam logic [7:0] DATA  = 8'h04;
  localparam logic [7:0] STAT  = 8'h05;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, wake = 1'b0, reg_rd = 1'b0, reg_rd2 = 1'b0;
  logic [7:0] reg_idx = 8'h00, reg_idx2 = 8'h00;
  logic [7:0] rd_data, rd_data2;
  int total = 0, bad = 0;

  resdata_reader #(.ROM_DEPTH(64), .FETCH_CYCLES(FETCH), .IMAGE_SEL(0)) u_resdata_reader (
    .clk(clk), .rst(rst), .wake(wake), .reg_rd(reg_rd), .reg_idx(reg_idx), .rd_data(rd_data));

  resdata_reader #(.ROM_DEPTH(8), .FETCH_CYCLES(1), .IMAGE_SEL(1)) u_resdata_reader_noend (
    .clk(clk), .rst(rst), .wake(1'b0), .reg_rd(reg_rd2), .reg_idx(reg_idx2), .rd_data(rd_data2));

  function automatic logic [7:0] exp_b(int i);
    case (i)
      0: return 8'h0A;  1: return 8'h10;  2: return 8'h00;  3: return 8'h15;
      4: return 8'h41;  5: return 8'h78;  6: return 8'h79;  7: return 8'h44;
      8: return 8'h45;  9: return 8'h82; 10: return 8'h03; 11: return 8'h00;
     12: return 8'h79; 13: return 8'h78; 14: return 8'h00; 15: return 8'h22;
     16: return 8'h20; 17: return 8'h00; 18: return 8'h79; 19: return 8'h5A;
      default: return 8'hEE;
    endcase
  endfunction

  function automatic logic [7:0] exp_noend(int i);
    case (i)
      0: return 8'h84;  1: return 8'hFF;  2: return 8'hFF;  3: return 8'h0A;
      4: return 8'h0D;  5: return 8'h10;  6: return 8'h13;  default: return 8'h16;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] v);
    reg_rd = 1'b1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 1'b0; v = rd_data;
  endtask

  task automatic rd2(input logic [7:0] idx, output logic [7:0] v);
    reg_rd2 = 1'b1; reg_idx2 = idx;
    @(negedge clk);
    reg_rd2 = 1'b0; v = rd_data2;
  endtask

  task automatic poll(string req);
    logic [7:0] s;
    int n = 0;
    do begin rd(STAT, s); n++; end while (s !== 8'h01 && n < 20);
    if (s !== 8'h01) chk(req, s, 8'h01);
  endtask

  task automatic poll2(string req);
    logic [7:0] s;
    int n = 0;
    do begin rd2(STAT, s); n++; end while (s !== 8'h01 && n < 20);
    if (s !== 8'h01) chk(req, s, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 data during reset", rd_data, 8'h00);
    rst = 1'b0;
    for (int j = 1; j <= FETCH + 1; j++) begin
      rd(STAT, v);
      chk("R1 status after reset", v, (j > FETCH) ? 8'h01 : 8'h00);
    end
  endtask

  task automatic t_first_byte();
    logic [7:0] v;
    rd(DATA, v);
    chk("R2 first byte", v, exp_b(0));
    for (int j = 1; j <= FETCH + 1; j++) begin
      rd(STAT, v);
      chk("R4 ready gap", v, (j > FETCH) ? 8'h01 : 8'h00);
    end
    rd(STAT, v);
    chk("R3 status format", v, 8'h01);
  endtask

  task automatic t_refused();
    logic [7:0] v;
    poll("R2 poll"); rd(DATA, v); chk("R2 byte 1", v, exp_b(1));
    poll("R2 poll"); rd(DATA, v); chk("R2 byte 2", v, exp_b(2));
    rd(DATA, v);
    chk("R5 read while busy", v, 8'h00);
    poll("R5 poll"); rd(DATA, v);
    chk("R5 pointer kept", v, exp_b(3));
  endtask

  task automatic t_other_idx();
    logic [7:0] v;
    poll("R9 poll");
    rd(8'h07, v); chk("R9 index 07", v, 8'h00);
    rd(8'h00, v); chk("R9 index 00", v, 8'h00);
    rd(8'hFF, v); chk("R9 index FF", v, 8'h00);
    rd(DATA, v);  chk("R9 pointer kept", v, exp_b(4));
  endtask

  task automatic t_walk();
    logic [7:0] v;
    for (int i = 5; i < 20; i++) begin
      poll("R6 poll");
      rd(DATA, v);
      chk("R6 stream byte", v, exp_b(i));
    end
  endtask

  task automatic t_end();
    logic [7:0] v;
    repeat (FETCH + 1) @(negedge clk);
    rd(STAT, v); chk("R7 status at end", v, 8'h01);
    for (int k = 0; k < 3; k++) begin
      rd(DATA, v); chk("R7 read past end", v, 8'h00);
    end
    rd(STAT, v); chk("R7 status stays", v, 8'h01);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    wake = 1'b1; reg_rd = 1'b1; reg_idx = DATA;
    @(negedge clk);
    wake = 1'b0; reg_rd = 1'b0;
    chk("R8 read with wake", rd_data, 8'h00);
    for (int j = 1; j <= FETCH + 1; j++) begin
      rd(STAT, v);
      chk("R8 ready after wake", v, (j > FETCH) ? 8'h01 : 8'h00);
    end
    rd(DATA, v); chk("R8 rewound after end", v, exp_b(0));
    poll("R8 poll"); rd(DATA, v); chk("R8 byte 1", v, exp_b(1));
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    poll("R8 poll"); rd(DATA, v); chk("R8 rewound mid stream", v, exp_b(0));
  endtask

  task automatic t_noend();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      poll2("R10 poll");
      rd2(DATA, v);
      chk("R10 byte", v, exp_noend(i));
    end
    repeat (3) @(negedge clk);
    rd2(DATA, v); chk("R10 past last entry", v, 8'h00);
    rd2(DATA, v); chk("R10 past last entry", v, 8'h00);
    rd2(STAT, v); chk("R10 status", v, 8'h01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_first_byte();
    t_refused();
    t_other_idx();
    t_walk();
    t_end();
    t_wake();
    t_noend();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule